// File: doc/BRIEF.md
# Interleaved MSI Interrupt Aggregator

This block collects message-signalled interrupts and turns them into a small set of interrupt lines. Each inbound write that lands on the target offset carries a vector number. The block latches that vector into one of several status groups. The spread across groups is interleaved rather than contiguous. Group g owns vectors g, g+NUM_GROUPS, g+2*NUM_GROUPS and so on. With the default sizes, group g holds vectors g, g+8, g+16 and g+24.

Software reaches the block through a 32-bit register port. Each group has three words: status, enable-set and enable-clear. A single end-of-interrupt word re-arms a group. Each group drives one interrupt output. The output gives a single-cycle pulse when the group holds an enabled pending bit and the group is armed. After a pulse, the group stays silent until software writes an end-of-interrupt for it. If a bit is still pending when that write arrives, the group pulses again.

Reads are combinational from the read address. Writes take effect at the next clock edge.

Top module: `msi_irq_agg`

## Requirements
- R1: An inbound write to offset 0x054 with data v in 0..31 sets status bit v>>3 of group v mod 8. The status word of group g is read at 0x104+16*g, with bit i in data bit i.
- R2: An inbound write is ignored when its offset is not 0x054 or its data exceeds 31.
- R3: Writing to 0x108+16*g sets each enable bit of group g whose data bit is 1. Data bits that are 0 have no effect. The enable word can be read at both 0x108+16*g and 0x10C+16*g.
- R4: Writing to 0x10C+16*g clears each enable bit of group g whose data bit is 1. All other enable bits are kept.
- R5: Writing to 0x104+16*g clears each status bit whose data bit is 1. Data bits that are 0 have no effect.
- R6: When an armed group has status AND enable nonzero after a clock edge, its output irq_o[g] is high for exactly the following cycle. This cycle is two edges after the write that completed the condition.
- R7: Once a group has pulsed, new or newly enabled pending bits produce no further pulse until that group is re-armed. A masked pending bit never pulses.
- R8: A register write of value g+4 to offset 0x050 re-arms group g. If the group is still pending, it pulses at the time R6 gives. Values outside 4..11 re-arm nothing.
- R9: If an inbound write sets a status bit in the same cycle that a register write clears it, the bit stays set.
- R10: Reset clears all status and enable bits, drives all outputs low and leaves every group armed.
- R11: A read of any offset that is not a group status or enable word returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 12 | Register write byte offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 12 | Register read byte offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| msi_wr_en | input | 1 | Inbound message write strobe |
| msi_wr_addr | input | 12 | Inbound message write offset |
| msi_wr_data | input | 32 | Inbound message data (vector number) |
| irq_o | output | 8 | One interrupt pulse line per group |

## Verification
Several kinds of internal fault are visible at the ports.

- A wrong vector-to-group decode shows up in the status word read back in the cycle after the inbound write. It also shows up on the irq line that pulses one cycle later.
- A corrupted arm flag shows up in two ways. It can produce a second pulse with no end-of-interrupt, or no pulse after a valid one. Either error appears within two edges of the triggering write.
- Wrong mask or clear handling changes the status and enable words immediately after the write.
- A reset fault is visible on the first read after reset is released.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
   localparam logic [11:0] EOI_OFS  = 12'h050;
   localparam logic [11:0] TGT_OFS  = 12'h054;
   localparam logic [11:0] GRP_BASE = 12'h100;
   localparam logic [3:0]  SUB_STAT = 4'h4;
   localparam logic [3:0]  SUB_ESET = 4'h8;
   localparam logic [3:0]  SUB_ECLR = 4'hC;
   localparam int          EOI_GRP_BIAS = 4;

   typedef enum logic [1:0] {
      REG_NONE,
      REG_STAT,
      REG_ESET,
      REG_ECLR
   } reg_kind_e;
endpackage

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
   import msi_agg_pkg::*;
#(
   parameter int NUM_GROUPS = 8,
   parameter int BITS       = 4,
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 32
) (
   input  logic                                   wr_en,
   input  logic [ADDR_W-1:0]                      wr_addr,
   input  logic [DATA_W-1:0]                      wr_data,
   input  logic [ADDR_W-1:0]                      rd_addr,
   input  logic                                   msi_en,
   input  logic [ADDR_W-1:0]                      msi_addr,
   input  logic [DATA_W-1:0]                      msi_data,
   output logic [NUM_GROUPS-1:0][BITS-1:0]        stat_set,
   output logic [NUM_GROUPS-1:0][BITS-1:0]        stat_clr,
   output logic [NUM_GROUPS-1:0][BITS-1:0]        en_set,
   output logic [NUM_GROUPS-1:0][BITS-1:0]        en_clr,
   output logic [NUM_GROUPS-1:0]                  eoi,
   output logic [$clog2(NUM_GROUPS)-1:0]          rd_grp,
   output reg_kind_e                              rd_kind
);
   localparam int GRP_W  = $clog2(NUM_GROUPS);
   localparam int VEC_W  = $clog2(NUM_GROUPS * BITS);
   localparam int HI_LSB = 4 + GRP_W;
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(GRP_BASE);

   function automatic reg_kind_e kind_of(input logic [ADDR_W-1:0] a);
      if ((a >> HI_LSB) != (BASE_A >> HI_LSB)) return REG_NONE;
      case (a[3:0])
         SUB_STAT: return REG_STAT;
         SUB_ESET: return REG_ESET;
         SUB_ECLR: return REG_ECLR;
         default:  return REG_NONE;
      endcase
   endfunction

   reg_kind_e        wr_kind;
   logic [GRP_W-1:0] wr_grp;
   logic             msi_hit;
   logic [VEC_W-1:0] vec;

   always_comb begin
      wr_kind = wr_en ? kind_of(wr_addr) : REG_NONE;
      wr_grp  = wr_addr[HI_LSB-1:4];
      rd_kind = kind_of(rd_addr);
      rd_grp  = rd_addr[HI_LSB-1:4];
      msi_hit = msi_en && (msi_addr == ADDR_W'(TGT_OFS)) && ((msi_data >> VEC_W) == '0);
      vec     = msi_data[VEC_W-1:0];
   end

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic sel;
      assign sel         = (wr_grp == GRP_W'(g));
      assign eoi[g]      = wr_en && (wr_addr == ADDR_W'(EOI_OFS))
                           && (wr_data == DATA_W'(g + EOI_GRP_BIAS));
      assign stat_clr[g] = (sel && wr_kind == REG_STAT) ? wr_data[BITS-1:0] : '0;
      assign en_set[g]   = (sel && wr_kind == REG_ESET) ? wr_data[BITS-1:0] : '0;
      assign en_clr[g]   = (sel && wr_kind == REG_ECLR) ? wr_data[BITS-1:0] : '0;
      for (genvar b = 0; b < BITS; b++) begin : g_bit
         assign stat_set[g][b] = msi_hit && (vec == VEC_W'(g + NUM_GROUPS * b));
      end
   end
endmodule

// File: rtl/msi_group.sv
module msi_group #(
   parameter int BITS = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [BITS-1:0] set_i,
   input  logic [BITS-1:0] clr_i,
   input  logic [BITS-1:0] en_set_i,
   input  logic [BITS-1:0] en_clr_i,
   input  logic            eoi_i,
   output logic [BITS-1:0] status_o,
   output logic [BITS-1:0] enable_o,
   output logic            irq_o
);
   logic [BITS-1:0] status_q, enable_q;
   logic            armed_q, irq_q, pend, fire;

   assign pend = |(status_q & enable_q);
   assign fire = armed_q && pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         enable_q <= '0;
         armed_q  <= 1'b1;
         irq_q    <= 1'b0;
      end else begin
         status_q <= (status_q & ~clr_i) | set_i;
         enable_q <= (enable_q | en_set_i) & ~en_clr_i;
         armed_q  <= (armed_q && !fire) || eoi_i;
         irq_q    <= fire;
      end
   end

   assign status_o = status_q;
   assign enable_o = enable_q;
   assign irq_o    = irq_q;

   assert_set_beats_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_i & clr_i) != '0) |=> ((status_q & $past(set_i & clr_i)) == $past(set_i & clr_i)));

   assert_w1c_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q & ~clr_i) != '0) |=>
      ((status_q & $past(status_q & ~clr_i)) == $past(status_q & ~clr_i)));

   assert_enable_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_set_i == '0 && en_clr_i == '0) |=> $stable(enable_q));

   assert_pulse_needs_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> $past(|(status_q & enable_q)));

   assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !eoi_i && !$past(eoi_i)) |=> !irq_q);
endmodule

// File: rtl/msi_irq_agg.sv
module msi_irq_agg
   import msi_agg_pkg::*;
#(
   parameter int NUM_GROUPS = 8,
   parameter int BITS       = 4,
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr_en,
   input  logic [ADDR_W-1:0]     reg_wr_addr,
   input  logic [DATA_W-1:0]     reg_wr_data,
   input  logic [ADDR_W-1:0]     reg_rd_addr,
   output logic [DATA_W-1:0]     reg_rd_data,
   input  logic                  msi_wr_en,
   input  logic [ADDR_W-1:0]     msi_wr_addr,
   input  logic [DATA_W-1:0]     msi_wr_data,
   output logic [NUM_GROUPS-1:0] irq_o
);
   localparam int GRP_W = $clog2(NUM_GROUPS);

   initial begin
      assert (NUM_GROUPS >= 2 && NUM_GROUPS <= 16 && (1 << GRP_W) == NUM_GROUPS)
         else $error("NUM_GROUPS must be a power of two in 2..16");
      assert (BITS >= 2 && (1 << $clog2(BITS)) == BITS && BITS <= DATA_W)
         else $error("BITS must be a power of two, at least 2");
      assert (ADDR_W >= 12) else $error("ADDR_W must be at least 12");
   end

   logic [NUM_GROUPS-1:0][BITS-1:0] stat_set, stat_clr, en_set, en_clr;
   logic [NUM_GROUPS-1:0][BITS-1:0] status_w, enable_w;
   logic [NUM_GROUPS-1:0]           eoi;
   logic [GRP_W-1:0]                rd_grp;
   reg_kind_e                       rd_kind;

   msi_reg_decode #(
      .NUM_GROUPS(NUM_GROUPS), .BITS(BITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) dec_i (
      .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
      .rd_addr(reg_rd_addr),
      .msi_en(msi_wr_en), .msi_addr(msi_wr_addr), .msi_data(msi_wr_data),
      .stat_set(stat_set), .stat_clr(stat_clr), .en_set(en_set), .en_clr(en_clr),
      .eoi(eoi), .rd_grp(rd_grp), .rd_kind(rd_kind)
   );

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      msi_group #(.BITS(BITS)) grp_i (
         .clk(clk), .rst_n(rst_n),
         .set_i(stat_set[g]), .clr_i(stat_clr[g]),
         .en_set_i(en_set[g]), .en_clr_i(en_clr[g]),
         .eoi_i(eoi[g]),
         .status_o(status_w[g]), .enable_o(enable_w[g]),
         .irq_o(irq_o[g])
      );
   end

   always_comb begin
      reg_rd_data = '0;
      case (rd_kind)
         REG_STAT:          reg_rd_data[BITS-1:0] = status_w[rd_grp];
         REG_ESET, REG_ECLR: reg_rd_data[BITS-1:0] = enable_w[rd_grp];
         default:           reg_rd_data = '0;
      endcase
   end

   assert_one_vector_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stat_set));

   assert_one_eoi_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(eoi));

   assert_quiet_without_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o != '0) |-> ($past(enable_w) != '0));
endmodule

// File: tb/msi_irq_agg_tb.sv
module msi_irq_agg_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [11:0] reg_wr_addr = '0;
   logic [31:0] reg_wr_data = '0;
   logic [11:0] reg_rd_addr = '0;
   logic [31:0] reg_rd_data;
   logic        msi_wr_en = 1'b0;
   logic [11:0] msi_wr_addr = '0;
   logic [31:0] msi_wr_data = '0;
   logic [7:0]  irq_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   msi_irq_agg dut_i (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
      .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
      .msi_wr_en(msi_wr_en), .msi_wr_addr(msi_wr_addr), .msi_wr_data(msi_wr_data),
      .irq_o(irq_o)
   );

   // {vector[4:0], group[2:0], bit[1:0]}
   localparam logic [9:0] TBL [8] = '{
      {5'd0,  3'd0, 2'd0}, {5'd7,  3'd7, 2'd0}, {5'd8,  3'd0, 2'd1},
      {5'd13, 3'd5, 2'd1}, {5'd31, 3'd7, 2'd3}, {5'd24, 3'd0, 2'd3},
      {5'd17, 3'd1, 2'd2}, {5'd22, 3'd6, 2'd2}
   };

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
      reg_rd_addr = a;
      #1;
      chk(reg_rd_data, exp, tag);
   endtask

   task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic msi_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      msi_wr_en = 1'b1; msi_wr_addr = a; msi_wr_data = d;
      @(negedge clk);
      msi_wr_en = 1'b0;
   endtask

   task automatic both_wr(input logic [11:0] ra, input logic [31:0] rd,
                          input logic [11:0] ma, input logic [31:0] md);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wr_addr = ra; reg_wr_data = rd;
      msi_wr_en = 1'b1; msi_wr_addr = ma; msi_wr_data = md;
      @(negedge clk);
      reg_wr_en = 1'b0; msi_wr_en = 1'b0;
   endtask

   // called at the negedge right after the write edge
   task automatic irq_seq(input logic [7:0] e1, input string tag);
      chk({24'd0, irq_o}, 32'd0, {tag, " irq before"});
      @(negedge clk);
      chk({24'd0, irq_o}, {24'd0, e1}, {tag, " irq pulse"});
      @(negedge clk);
      chk({24'd0, irq_o}, 32'd0, {tag, " irq after"});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      for (int g = 0; g < 8; g++) begin
         rd_chk(12'h104 + 12'(16*g), 0, "R10 status");
         rd_chk(12'h108 + 12'(16*g), 0, "R10 enable");
      end
      chk({24'd0, irq_o}, 0, "R10 irq");
      rd_chk(12'h054, 0, "R11 target read");
      rd_chk(12'h200, 0, "R11 unmapped");
      rd_chk(12'h100, 0, "R11 group hole");

      for (int g = 0; g < 8; g++) reg_wr(12'h108 + 12'(16*g), 32'hF);
      chk({24'd0, irq_o}, 0, "R3 enable no pending");

      // R1 table walk: decode, pulse, W1C, EOI
      for (int i = 0; i < 8; i++) begin
         logic [4:0] v; logic [2:0] g; logic [1:0] b;
         {v, g, b} = TBL[i];
         msi_wr(12'h054, {27'd0, v});
         rd_chk(12'h104 + 12'(16*g), 32'(1) << b, "R1 status decode");
         irq_seq(8'(1) << g, "R6 table");
         reg_wr(12'h104 + 12'(16*g), 32'(1) << b);
         rd_chk(12'h104 + 12'(16*g), 0, "R5 clear");
         reg_wr(12'h050, 32'(g) + 4);
         irq_seq(8'd0, "R8 eoi idle");
      end
      for (int g = 0; g < 8; g++) reg_wr(12'h10C + 12'(16*g), 32'hF);
      rd_chk(12'h158, 0, "R4 all cleared");

      // R2 ignored inbound writes
      msi_wr(12'h058, 3);
      rd_chk(12'h134, 0, "R2 wrong offset");
      msi_wr(12'h054, 32'h23);
      rd_chk(12'h134, 0, "R2 data above 31");

      // R7 masked pending, R3 enable set
      msi_wr(12'h054, 2);
      irq_seq(8'd0, "R7 masked");
      rd_chk(12'h124, 1, "R1 group2 bit0");
      reg_wr(12'h128, 0);
      rd_chk(12'h128, 0, "R3 zero write");
      reg_wr(12'h128, 1);
      irq_seq(8'h04, "R6 enable completes");
      rd_chk(12'h128, 1, "R3 read eset");
      rd_chk(12'h12C, 1, "R3 read eclr");

      // R7 no re-pulse while disarmed
      msi_wr(12'h054, 10);
      irq_seq(8'd0, "R7 disarmed");
      rd_chk(12'h124, 3, "R1 group2 bits");

      // R8 EOI values
      reg_wr(12'h050, 12);
      irq_seq(8'd0, "R8 eoi 12 ignored");
      reg_wr(12'h050, 2);
      irq_seq(8'd0, "R8 eoi 2 ignored");
      reg_wr(12'h050, 6);
      irq_seq(8'h04, "R8 eoi re-pulse");

      // R5 W1C
      reg_wr(12'h124, 0);
      rd_chk(12'h124, 3, "R5 zero write");
      reg_wr(12'h124, 1);
      rd_chk(12'h124, 2, "R5 single clear");

      // R4 enable clear
      reg_wr(12'h128, 2);
      reg_wr(12'h12C, 1);
      rd_chk(12'h128, 2, "R4 eset view");
      rd_chk(12'h12C, 2, "R4 eclr view");
      chk({24'd0, irq_o}, 0, "R7 still disarmed");

      // R9 set beats clear
      both_wr(12'h124, 4, 12'h054, 18);
      rd_chk(12'h124, 6, "R9 new bit");
      both_wr(12'h124, 2, 12'h054, 10);
      rd_chk(12'h124, 6, "R9 held bit");

      // R10 mid-run reset re-arms
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd_chk(12'h124, 0, "R10 status after reset");
      rd_chk(12'h128, 0, "R10 enable after reset");
      reg_wr(12'h158, 1);
      msi_wr(12'h054, 5);
      irq_seq(8'h20, "R10 armed after reset");

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule